// File: doc/BRIEF.md
# Dual-Mode Sample Rate Generator

This block turns one fixed 100 MHz timebase into a stream of one-cycle sample-enable pulses. The rate comes from one of two engines. The first is an integer counter that pulses once every N timebase cycles. The second is a 48-bit phase accumulator that pulses whenever its addition carries out of the top bit. The accumulator gives very fine rate steps, at the cost of a less regular pulse spacing.

A configuration is written with the `load` strobe. In divide mode the divisor is given directly, and in fine mode the tuning word is given directly. In automatic mode the block receives a target rate in whole hertz. It then runs a sequential restoring division of the timebase frequency by that rate. When the division is exact and the quotient is a legal divisor, the integer counter is used with that quotient. Otherwise the phase accumulator is used with the supplied tuning word.

While a new setting is being worked out, the block reports busy and keeps the output quiet. The new setting starts on the first cycle after busy falls. A load that cannot be honoured raises an error flag and leaves the running configuration untouched.

Top module: `samp_rate_gen`

## Requirements
- R1: After reset, `samp_en`, `busy`, `cfg_err` and `mode_sel` are all 0, and `samp_en` stays 0 until a configuration has been applied.
- R2: In divide mode (`cfg_mode`=0) with N = `cfg_div_m1`+1, counting the first cycle after `busy` falls as cycle 1, `samp_en` is high exactly in cycles k·N. With N=1, `samp_en` is high in every cycle.
- R3: `mode_sel` reports the engine in use: 0 for the integer divider, 1 for the phase accumulator. It changes only on the cycle after `busy` falls.
- R4: In fine mode (`cfg_mode`=1) with tuning word T, counting from cycle 1 after `busy` falls, `samp_en` is high in cycle i exactly when floor(i·T/2^48) differs from floor((i−1)·T/2^48).
- R5: In automatic mode (`cfg_mode`=2), if 100,000,000 divided by `cfg_freq_hz` leaves no remainder and the quotient q satisfies 1 ≤ q ≤ 4,194,304, the block selects the divider with N=q.
- R6: In automatic mode with a nonzero remainder, the block selects the accumulator and uses `cfg_tuning` as T.
- R7: In automatic mode with an exact quotient above 4,194,304, the block selects the accumulator. An exact quotient of 4,194,304 or less still selects the divider.
- R8: A divide or fine load holds `busy` high for exactly 1 cycle. An automatic load holds it high for exactly 28 cycles. `samp_en` is 0 whenever `busy` is 1.
- R9: A load with `cfg_mode`=3, or an automatic load with `cfg_freq_hz` equal to 0 or above 100,000,000, sets `cfg_err` on the next cycle and does not raise `busy`. The running rate, phase and `mode_sel` continue unchanged. The next accepted load clears `cfg_err`.
- R10: A `load` pulse while `busy` is high is ignored: it does not lengthen `busy` and does not change the configuration being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 0 divide, 1 fine, 2 automatic, 3 reserved |
| cfg_div_m1 | input | 22 | Divisor minus one for divide mode |
| cfg_freq_hz | input | 27 | Target rate in hertz for automatic mode |
| cfg_tuning | input | 48 | Phase increment for the accumulator |
| load | input | 1 | One-cycle strobe that accepts the configuration inputs |
| busy | output | 1 | High while a new setting is pending |
| cfg_err | output | 1 | High after a rejected load |
| mode_sel | output | 1 | Engine in use: 0 divider, 1 accumulator |
| samp_en | output | 1 | Sample-enable pulse |

## Verification
The hardest case to reach from the ports is an automatic decision at the edge of the legal divisor range. There the division is exact, but the quotient lies just above or just below 4,194,304. Rates of 20 Hz and 25 Hz lie on either side of that limit, and the bench drives both. A second hard case is a load strobe that arrives in the middle of the 27-step division. The bench raises `load` several cycles into a calculation and checks that neither the busy length nor the result changes. Rejected loads are sent while a divider stream is running, so the bench can see that the pulse count carries on unchanged.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    MODE_DIV  = 2'd0,
    MODE_FINE = 2'd1,
    MODE_AUTO = 2'd2,
    MODE_RSVD = 2'd3
  } req_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIRECT = 2'd1,
    ST_CALC   = 2'd2
  } ctl_state_e;

  // a requested rate is usable when nonzero and not above the timebase
  function automatic logic freq_ok(input int unsigned f, input int unsigned fmax);
    return (f != 0) && (f <= fmax);
  endfunction

  // an integer quotient is a legal divisor within 1..nmax
  function automatic logic quot_ok(input int unsigned q, input int unsigned nmax);
    return (q >= 1) && (q <= nmax);
  endfunction
endpackage

// File: rtl/srg_int_div.sv
module srg_int_div #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] n_m1,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt == n_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + W'(1);
  end

  // R2: the count never passes the divisor it serves
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt <= n_m1));
endmodule

// File: rtl/srg_phase_acc.sv
module srg_phase_acc #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] tw,
  output logic         carry
);
  logic [W-1:0] acc;
  logic [W:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, tw};
  assign carry = sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (restart) acc <= '0;
    else              acc <= sum[W-1:0];
  end

  // R4: a carry always leaves the phase lower than before
  p_carry_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !restart) |=> (acc < $past(acc)));
endmodule

// File: rtl/srg_exact_div.sv
module srg_exact_div #(
  parameter int          W        = 27,
  parameter int unsigned DIVIDEND = 100_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic         rem_zero
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic [W:0]    diff;
  logic          fits;

  assign shifted  = {rem[W-1:0], quo[W-1]};
  assign diff     = shifted - {1'b0, divisor};
  assign fits     = shifted >= {1'b0, divisor};
  assign quot     = quo;
  assign rem_zero = (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        quo <= W'(DIVIDEND);
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? diff : shifted;
        quo <= {quo[W-2:0], fits};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5: an exact result multiplies back to the dividend
  p_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rem_zero) |-> ((2*W)'(quo) * (2*W)'(divisor) == (2*W)'(DIVIDEND)));
endmodule

// File: rtl/samp_rate_gen.sv
module samp_rate_gen import srg_pkg::*; #(
  parameter int TB_HZ  = 100_000_000,
  parameter int FREQ_W = 27,
  parameter int DIVN_W = 22,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [DIVN_W-1:0] cfg_div_m1,
  input  logic [FREQ_W-1:0] cfg_freq_hz,
  input  logic [ACC_W-1:0]  cfg_tuning,
  input  logic              load,
  output logic              busy,
  output logic              cfg_err,
  output logic              mode_sel,
  output logic              samp_en
);
  localparam int NMAX = 1 << DIVN_W;

  ctl_state_e        st;
  logic [1:0]        pend_mode;
  logic [DIVN_W-1:0] pend_n_m1;
  logic [FREQ_W-1:0] pend_freq;
  logic [ACC_W-1:0]  pend_tw;
  logic [DIVN_W-1:0] act_n_m1;
  logic [ACC_W-1:0]  act_tw;
  logic              live;

  // named events for the assertions
  logic              take;
  logic              bad;
  logic              reject;
  logic              accept;
  logic              start_calc;
  logic              apply_direct;
  logic              apply_calc;
  logic              apply;
  logic              div_done;
  logic              div_rem_zero;
  logic [FREQ_W-1:0] div_quot;
  logic              exact_ok;
  logic [DIVN_W-1:0] q_m1;
  logic              div_tick;
  logic              dds_carry;

  assign take   = load && (st == ST_IDLE);
  assign bad    = (cfg_mode == MODE_RSVD) ||
                  ((cfg_mode == MODE_AUTO) && !freq_ok(32'(cfg_freq_hz), 32'(TB_HZ)));
  assign reject = take && bad;
  assign accept = take && !bad;
  assign start_calc   = accept && (cfg_mode == MODE_AUTO);
  assign apply_direct = (st == ST_DIRECT);
  assign apply_calc   = (st == ST_CALC) && div_done;
  assign apply        = apply_direct || apply_calc;
  assign exact_ok     = div_rem_zero && quot_ok(32'(div_quot), 32'(NMAX));
  assign q_m1         = div_quot[DIVN_W-1:0] - DIVN_W'(1);

  assign busy    = (st != ST_IDLE);
  assign samp_en = live && !busy && (mode_sel ? dds_carry : div_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend_mode <= '0;
      pend_n_m1 <= '0;
      pend_freq <= '0;
      pend_tw   <= '0;
      act_n_m1  <= '0;
      act_tw    <= '0;
      live      <= 1'b0;
      mode_sel  <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      if (reject)      cfg_err <= 1'b1;
      else if (accept) cfg_err <= 1'b0;

      if (accept) begin
        pend_mode <= cfg_mode;
        pend_n_m1 <= cfg_div_m1;
        pend_freq <= cfg_freq_hz;
        pend_tw   <= cfg_tuning;
        st        <= (cfg_mode == MODE_AUTO) ? ST_CALC : ST_DIRECT;
      end

      if (apply_direct) begin
        mode_sel <= (pend_mode == MODE_FINE);
        act_n_m1 <= pend_n_m1;
        act_tw   <= pend_tw;
        live     <= 1'b1;
        st       <= ST_IDLE;
      end

      if (apply_calc) begin
        if (exact_ok) begin
          mode_sel <= 1'b0;
          act_n_m1 <= q_m1;
        end else begin
          mode_sel <= 1'b1;
          act_tw   <= pend_tw;
        end
        live <= 1'b1;
        st   <= ST_IDLE;
      end
    end
  end

  srg_exact_div #(.W(FREQ_W), .DIVIDEND(TB_HZ)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start_calc), .divisor(pend_freq),
    .done(div_done), .quot(div_quot), .rem_zero(div_rem_zero)
  );

  srg_int_div #(.W(DIVN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(apply), .n_m1(act_n_m1), .tick(div_tick)
  );

  srg_phase_acc #(.W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .restart(apply), .tw(act_tw), .carry(dds_carry)
  );

  // R8: output stays quiet while a setting is pending
  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !samp_en);
  // R8: applying a setting ends the busy period
  p_apply_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !busy);
  // R9: a rejected load flags an error without going busy
  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (cfg_err && !busy));
  // R9: an accepted load clears the error
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cfg_err);
  // R3: the engine selection moves only when a setting is applied
  p_hold_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(mode_sel));
  // R10: a busy block does not take a new load
  p_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load) |=> $stable(pend_tw));
endmodule

// File: tb/samp_rate_gen_tb.sv
module samp_rate_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [21:0] cfg_div_m1 = '0;
  logic [26:0] cfg_freq_hz = '0;
  logic [47:0] cfg_tuning = '0;
  logic        load = 1'b0;
  logic        busy, cfg_err, mode_sel, samp_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  samp_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_div_m1(cfg_div_m1),
    .cfg_freq_hz(cfg_freq_hz), .cfg_tuning(cfg_tuning), .load(load),
    .busy(busy), .cfg_err(cfg_err), .mode_sel(mode_sel), .samp_en(samp_en)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a load at a falling edge, then count the busy cycles
  task automatic do_load(input logic [1:0] m, input logic [21:0] nm1, input logic [26:0] f,
                         input logic [47:0] tw, output int bcyc, output bit en_seen);
    cfg_mode = m; cfg_div_m1 = nm1; cfg_freq_hz = f; cfg_tuning = tw; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    bcyc = 0; en_seen = 0;
    while (busy) begin
      if (samp_en) en_seen = 1;
      bcyc++;
      @(negedge clk);
    end
  endtask

  // compare the stream against the expected pattern, from cycle 1 after busy falls
  task automatic check_stream(input string req, input bit fine, input longint unsigned val,
                              input int cycles);
    bit bad = 0;
    int bad_i = 0;
    bit bad_a = 0, bad_e = 0;
    for (int i = 1; i <= cycles; i++) begin
      bit e;
      if (fine) begin
        longint unsigned a = (longint'(i) * val) >> 48;
        longint unsigned b = (longint'(i - 1) * val) >> 48;
        e = (a != b);
      end else begin
        e = ((longint'(i) % val) == 0);
      end
      if (!bad && samp_en !== e) begin
        bad = 1; bad_i = i; bad_a = samp_en; bad_e = e;
      end
      @(negedge clk);
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, bad_i, bad_a, bad_e);
    end
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      if (samp_en) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 samp_en", samp_en, 0);
    check("R1 busy", busy, 0);
    check("R1 cfg_err", cfg_err, 0);
    check("R1 mode_sel", mode_sel, 0);
  endtask

  task automatic t_divide();
    int b; bit en;
    do_load(2'd0, 22'd0, 27'd0, 48'd0, b, en);
    check("R8 direct busy length", b, 1);
    check("R3 mode_sel divide", mode_sel, 0);
    check_stream("R2 N=1", 0, 1, 20);
    do_load(2'd0, 22'd4, 27'd0, 48'd0, b, en);
    check_stream("R2 N=5", 0, 5, 40);
  endtask

  task automatic t_fine();
    int b; bit en;
    do_load(2'd1, 22'd0, 27'd0, 48'h4000_0000_0000, b, en);
    check("R8 fine busy length", b, 1);
    check("R3 mode_sel fine", mode_sel, 1);
    check_stream("R4 T=2^46", 1, 64'h4000_0000_0000, 40);
    do_load(2'd1, 22'd0, 27'd0, 48'h3000_1234_5678, b, en);
    check_stream("R4 T=odd", 1, 64'h3000_1234_5678, 100);
  endtask

  task automatic t_auto();
    int b; bit en;
    do_load(2'd2, 22'd0, 27'd25_000_000, 48'h1, b, en);
    check("R8 auto busy length", b, 28);
    check("R8 quiet while busy", en, 0);
    check("R5 mode_sel exact", mode_sel, 0);
    check_stream("R5 N=4", 0, 4, 40);
    do_load(2'd2, 22'd9, 27'd100_000_000, 48'h1, b, en);
    check("R5 mode_sel 100M", mode_sel, 0);
    check_stream("R5 N=1", 0, 1, 20);
    do_load(2'd2, 22'd0, 27'd30_000_000, 48'h5555_5555_5555, b, en);
    check("R6 mode_sel inexact", mode_sel, 1);
    check_stream("R6 tuning used", 1, 64'h5555_5555_5555, 60);
    do_load(2'd2, 22'd0, 27'd20, 48'h8000_0000_0000, b, en);
    check("R7 quotient over limit", mode_sel, 1);
    check_stream("R7 fallback stream", 1, 64'h8000_0000_0000, 20);
    do_load(2'd2, 22'd0, 27'd25, 48'h8000_0000_0000, b, en);
    check("R7 quotient under limit", mode_sel, 0);
    check_stream("R7 N=4000000 quiet", 0, 4_000_000, 50);
  endtask

  task automatic t_reject();
    int b, n; bit en;
    do_load(2'd0, 22'd3, 27'd0, 48'd0, b, en);
    count_pulses(7, n);
    do_load(2'd2, 22'd0, 27'd0, 48'hFFFF, b, en);
    check("R9 zero freq busy", b, 0);
    check("R9 zero freq err", cfg_err, 1);
    count_pulses(40, n);
    check("R9 stream kept", n, 10);
    check("R9 mode kept", mode_sel, 0);
    do_load(2'd2, 22'd0, 27'd100_000_001, 48'hFFFF, b, en);
    check("R9 high freq err", cfg_err, 1);
    do_load(2'd3, 22'd0, 27'd1000, 48'hFFFF, b, en);
    check("R9 reserved mode busy", b, 0);
    check("R9 reserved mode err", cfg_err, 1);
    count_pulses(40, n);
    check("R9 stream kept again", n, 10);
    do_load(2'd0, 22'd1, 27'd0, 48'd0, b, en);
    check("R9 err cleared", cfg_err, 0);
  endtask

  task automatic t_busy_load();
    int b = 0;
    cfg_mode = 2'd2; cfg_freq_hz = 27'd50_000_000; cfg_tuning = 48'h1; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (busy) b++;
      @(negedge clk);
    end
    cfg_mode = 2'd1; cfg_freq_hz = 27'd7; cfg_tuning = 48'hFFFF_0000_0000; load = 1'b1;
    if (busy) b++;
    @(negedge clk);
    load = 1'b0;
    while (busy) begin
      b++;
      @(negedge clk);
    end
    check("R10 busy not extended", b, 28);
    check("R10 first result kept", mode_sel, 0);
    check_stream("R10 N=2", 0, 2, 20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (4) @(negedge clk);
    check("R1 idle before config", samp_en, 0);
    t_divide();
    t_fine();
    t_auto();
    t_reject();
    t_busy_load();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule